// File: doc/BRIEF.md
# Burst Traffic Generator and Read-Back Checker

This block is a bus manager that exercises a memory path the way a simple DMA engine would. In its write phase it issues a programmed number of fixed-size bursts to consecutive addresses, each filled with a predictable data pattern. In its read phase it fetches the same region and compares every returned beat against the pattern it expects, counting the beats that match.

A small register port lets software set the base address, the burst count and the cache, protection and user sideband values, and start either phase. Each phase times itself in clock cycles from its first address request to its final response. At most four bursts are in flight on each path, so the cycle counts show how the memory path behaves under a shallow request window.

Top module: `burst_traffic_checker`

## Requirements
- R1: Every burst is 64 bytes as four 128-bit beats: length field 3, size field 4 (16 bytes), burst type 1 (incrementing), all byte strobes set, and the last flag high on the fourth write beat only.
- R2: Burst i of a phase is addressed at base + 64*i, on both the write and the read address channels, and an address request stays valid and stable until it is accepted.
- R3: Global beat k of a transfer (k counted from 0 over the whole phase) carries the 32-bit value k in each of its four 32-bit lanes.
- R4: No more than 4 write bursts are accepted without their write response, and no more than 4 read bursts are accepted without their last data beat.
- R5: The write cycle count (register 0x10) equals the number of cycles from the first cycle with write address valid to the cycle of the last write response handshake, both included; the read cycle count (register 0x14) is the same from the first read address valid cycle to the last read beat handshake.
- R6: The match count (register 0x18) is the number of read beats whose data equals the R3 pattern for that beat.
- R7: Status register 0x00 reads write busy in bit 0, read busy in bit 1, write done in bit 2, read done in bit 3; a done bit sets once every response of its phase has arrived and clears when that phase is started again.
- R8: Writing bit 0 of register 0x00 starts the write phase and bit 1 starts the read phase; a start while either phase is busy is ignored, and with both bits set only the write phase starts.
- R9: Register 0x0C holds cache in bits 3:0, protection in bits 6:4 and user in bit 8; these drive the cache, protection and user fields of both address channels.
- R10: With a burst count of zero a started phase issues no address, sets its done bit and reports zero cycles.
- R11: After reset all registers read zero (base at 0x04, burst count at 0x08) and no address request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | LITE_AW | Register write address |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wdata | input | 32 | Register write data |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_bresp | output | 2 | Register write response (always OKAY) |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_araddr | input | LITE_AW | Register read address |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response (always OKAY) |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| m_awaddr | output | 32 | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awcache | output | 4 | Write cache attributes |
| m_awprot | output | 3 | Write protection attributes |
| m_awuser | output | USER_W | Write user sideband |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 128 | Write beat data |
| m_wstrb | output | 16 | Write byte strobes |
| m_wlast | output | 1 | Last write beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arcache | output | 4 | Read cache attributes |
| m_arprot | output | 3 | Read protection attributes |
| m_aruser | output | USER_W | Read user sideband |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 128 | Read beat data |
| m_rlast | input | 1 | Last read beat of burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A register write turns into a start pulse one cycle after its handshake, and the phase drives its first address request in the cycle after that, so the bench records the first valid address cycle and the final response cycle itself from the bus and derives the expected cycle counts from those two edges rather than from any fixed latency. Done bits rise at the clock edge of the last response, and register reads return data one cycle after the read address is accepted, so the bench polls status and compares every value at the falling edge after the read data appears. Start commands issued mid-phase are judged by counting address handshakes on the bus before the next start, and the in-flight limit is judged by the bench's own running count of accepted-but-unanswered bursts against a memory model whose response latency is long enough for the limit to bind.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 128;
  localparam int WORD_W      = 32;
  localparam int BURST_BEATS = 4;
  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int BURST_BYTES = BURST_BEATS * BEAT_BYTES;
  localparam int LANES       = DATA_W / WORD_W;

  // Address of burst number idx counted from the phase base.
  function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] idx);
    return base + idx * ADDR_W'(BURST_BYTES);
  endfunction

  // Global beat number inside a phase.
  function automatic logic [WORD_W-1:0] beat_index(input logic [WORD_W-1:0] burst,
                                                  input logic [WORD_W-1:0] beat);
    return burst * WORD_W'(BURST_BEATS) + beat;
  endfunction

  // Data carried by a beat: its index copied into every lane.
  function automatic logic [DATA_W-1:0] beat_pattern(input logic [WORD_W-1:0] idx);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*WORD_W +: WORD_W] = idx;
    return v;
  endfunction
endpackage

// File: rtl/btc_regs.sv
module btc_regs
  import btc_pkg::*;
#(
  parameter int LITE_AW = 5,
  parameter int CNT_W   = 16,
  parameter int USER_W  = 1,
  parameter int CYC_W   = 32,
  parameter int OK_W    = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LITE_AW-1:0] s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [31:0]        s_wdata,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [LITE_AW-1:0] s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [31:0]        s_rdata,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic               cmd_wr,
  output logic               cmd_rd,
  output logic [ADDR_W-1:0]  base,
  output logic [CNT_W-1:0]   n_bursts,
  output logic [3:0]         sb_cache,
  output logic [2:0]         sb_prot,
  output logic [USER_W-1:0]  sb_user,
  input  logic [3:0]         status,
  input  logic [CYC_W-1:0]   wr_cycles,
  input  logic [CYC_W-1:0]   rd_cycles,
  input  logic [OK_W-1:0]    ok_count
);
  localparam int IDX_W = LITE_AW - 2;

  logic             wr_take;
  logic [IDX_W-1:0] w_idx, r_idx;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign wr_take   = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_take;
  assign s_wready  = wr_take;
  assign s_arready = !s_rvalid;
  assign w_idx     = s_awaddr[LITE_AW-1:2];
  assign r_idx     = s_araddr[LITE_AW-1:2];
  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata};

  always_comb begin
    case (r_idx)
      IDX_W'(0): rd_mux = {28'd0, status};
      IDX_W'(1): rd_mux = 32'(base);
      IDX_W'(2): rd_mux = 32'(n_bursts);
      IDX_W'(3): rd_mux = 32'({sb_user, 1'b0, sb_prot, sb_cache});
      IDX_W'(4): rd_mux = 32'(wr_cycles);
      IDX_W'(5): rd_mux = 32'(rd_cycles);
      IDX_W'(6): rd_mux = 32'(ok_count);
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      cmd_wr   <= 1'b0;
      cmd_rd   <= 1'b0;
      base     <= '0;
      n_bursts <= '0;
      sb_cache <= '0;
      sb_prot  <= '0;
      sb_user  <= '0;
    end else begin
      cmd_wr <= 1'b0;
      cmd_rd <= 1'b0;
      if (wr_take) begin
        s_bvalid <= 1'b1;
        case (w_idx)
          IDX_W'(0): begin
            cmd_wr <= s_wdata[0];
            cmd_rd <= s_wdata[1];
          end
          IDX_W'(1): base     <= s_wdata[ADDR_W-1:0];
          IDX_W'(2): n_bursts <= s_wdata[CNT_W-1:0];
          IDX_W'(3): begin
            sb_cache <= s_wdata[3:0];
            sb_prot  <= s_wdata[6:4];
            sb_user  <= s_wdata[8 +: USER_W];
          end
          default: ;
        endcase
      end else if (s_bvalid && s_bready) begin
        s_bvalid <= 1'b0;
      end
      if (s_arvalid && s_arready) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_mux;
      end else if (s_rvalid && s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/btc_wr_engine.sv
module btc_wr_engine
  import btc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int CYC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  n_bursts,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycles,
  output logic [CNT_W-1:0]  inflight
);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  logic              run_q, done_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  total_q, aw_cnt, w_cnt, b_cnt;
  logic [BEAT_W-1:0] beat_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              aw_fire, w_fire, b_fire, last_b;

  assign inflight = aw_cnt - b_cnt;
  assign aw_valid = run_q && (aw_cnt != total_q) && (inflight < CNT_W'(MAX_OUT));
  assign aw_addr  = burst_addr(base_q, ADDR_W'(aw_cnt));
  // data of a burst only follows its own accepted address
  assign w_valid  = run_q && (w_cnt != aw_cnt);
  assign w_last   = (beat_q == BEAT_W'(BURST_BEATS - 1));
  assign w_data   = beat_pattern(beat_index(WORD_W'(w_cnt), WORD_W'(beat_q)));
  assign b_ready  = run_q;
  assign aw_fire  = aw_valid && aw_ready;
  assign w_fire   = w_valid && w_ready;
  assign b_fire   = b_valid && run_q;
  assign last_b   = b_fire && ((b_cnt + CNT_W'(1)) == total_q);
  assign busy     = run_q;
  assign done     = done_q;
  assign cycles   = cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      base_q  <= '0;
      total_q <= '0;
      aw_cnt  <= '0;
      w_cnt   <= '0;
      b_cnt   <= '0;
      beat_q  <= '0;
      cyc_q   <= '0;
    end else if (start) begin
      run_q   <= (n_bursts != '0);
      done_q  <= (n_bursts == '0);
      base_q  <= base;
      total_q <= n_bursts;
      aw_cnt  <= '0;
      w_cnt   <= '0;
      b_cnt   <= '0;
      beat_q  <= '0;
      cyc_q   <= '0;
    end else if (run_q) begin
      cyc_q <= cyc_q + CYC_W'(1);
      if (aw_fire) aw_cnt <= aw_cnt + CNT_W'(1);
      if (w_fire) begin
        if (w_last) begin
          beat_q <= '0;
          w_cnt  <= w_cnt + CNT_W'(1);
        end else begin
          beat_q <= beat_q + BEAT_W'(1);
        end
      end
      if (b_fire) b_cnt <= b_cnt + CNT_W'(1);
      if (last_b) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/btc_rd_engine.sv
module btc_rd_engine
  import btc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int CYC_W   = 32,
  parameter int OK_W    = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  n_bursts,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  input  logic              r_valid,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  output logic              r_ready,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycles,
  output logic [OK_W-1:0]   ok_count,
  output logic [CNT_W-1:0]  inflight
);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  logic              run_q, done_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  total_q, ar_cnt, r_cnt;
  logic [BEAT_W-1:0] beat_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [OK_W-1:0]   ok_q;
  logic              ar_fire, r_fire, beat_ok, last_r;

  assign inflight = ar_cnt - r_cnt;
  assign ar_valid = run_q && (ar_cnt != total_q) && (inflight < CNT_W'(MAX_OUT));
  assign ar_addr  = burst_addr(base_q, ADDR_W'(ar_cnt));
  assign r_ready  = run_q;
  assign ar_fire  = ar_valid && ar_ready;
  assign r_fire   = r_valid && run_q;
  assign beat_ok  = (r_data == beat_pattern(beat_index(WORD_W'(r_cnt), WORD_W'(beat_q))));
  assign last_r   = r_fire && r_last && ((r_cnt + CNT_W'(1)) == total_q);
  assign busy     = run_q;
  assign done     = done_q;
  assign cycles   = cyc_q;
  assign ok_count = ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      base_q  <= '0;
      total_q <= '0;
      ar_cnt  <= '0;
      r_cnt   <= '0;
      beat_q  <= '0;
      cyc_q   <= '0;
      ok_q    <= '0;
    end else if (start) begin
      run_q   <= (n_bursts != '0);
      done_q  <= (n_bursts == '0);
      base_q  <= base;
      total_q <= n_bursts;
      ar_cnt  <= '0;
      r_cnt   <= '0;
      beat_q  <= '0;
      cyc_q   <= '0;
      ok_q    <= '0;
    end else if (run_q) begin
      cyc_q <= cyc_q + CYC_W'(1);
      if (ar_fire) ar_cnt <= ar_cnt + CNT_W'(1);
      if (r_fire) begin
        if (beat_ok) ok_q <= ok_q + OK_W'(1);
        if (r_last) begin
          beat_q <= '0;
          r_cnt  <= r_cnt + CNT_W'(1);
        end else begin
          beat_q <= beat_q + BEAT_W'(1);
        end
      end
      if (last_r) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_traffic_checker.sv
module burst_traffic_checker
  import btc_pkg::*;
#(
  parameter int LITE_AW = 5,
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int USER_W  = 1,
  parameter int CYC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LITE_AW-1:0] s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [31:0]        s_wdata,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [LITE_AW-1:0] s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [31:0]        m_awaddr,
  output logic [7:0]         m_awlen,
  output logic [2:0]         m_awsize,
  output logic [1:0]         m_awburst,
  output logic [3:0]         m_awcache,
  output logic [2:0]         m_awprot,
  output logic [USER_W-1:0]  m_awuser,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [127:0]       m_wdata,
  output logic [15:0]        m_wstrb,
  output logic               m_wlast,
  output logic               m_wvalid,
  input  logic               m_wready,
  input  logic               m_bvalid,
  output logic               m_bready,
  output logic [31:0]        m_araddr,
  output logic [7:0]         m_arlen,
  output logic [2:0]         m_arsize,
  output logic [1:0]         m_arburst,
  output logic [3:0]         m_arcache,
  output logic [2:0]         m_arprot,
  output logic [USER_W-1:0]  m_aruser,
  output logic               m_arvalid,
  input  logic               m_arready,
  input  logic [127:0]       m_rdata,
  input  logic               m_rlast,
  input  logic               m_rvalid,
  output logic               m_rready
);
  localparam int OK_W    = CNT_W + $clog2(BURST_BEATS);
  localparam int SIZE_CD = $clog2(BEAT_BYTES);

  logic              cmd_wr, cmd_rd, wr_start, rd_start, any_busy;
  logic              wr_busy, wr_done, rd_busy, rd_done;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  n_bursts, wr_inflight, rd_inflight;
  logic [3:0]        sb_cache;
  logic [2:0]        sb_prot;
  logic [USER_W-1:0] sb_user;
  logic [CYC_W-1:0]  wr_cycles, rd_cycles;
  logic [OK_W-1:0]   ok_count;

  // start gating: nothing starts while a phase runs; write has priority
  assign any_busy = wr_busy || rd_busy;
  assign wr_start = cmd_wr && !any_busy;
  assign rd_start = cmd_rd && !cmd_wr && !any_busy;

  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;

  btc_regs #(.LITE_AW(LITE_AW), .CNT_W(CNT_W), .USER_W(USER_W), .CYC_W(CYC_W), .OK_W(OK_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .base(base), .n_bursts(n_bursts),
    .sb_cache(sb_cache), .sb_prot(sb_prot), .sb_user(sb_user),
    .status({rd_done, wr_done, rd_busy, wr_busy}),
    .wr_cycles(wr_cycles), .rd_cycles(rd_cycles), .ok_count(ok_count)
  );

  btc_wr_engine #(.CNT_W(CNT_W), .MAX_OUT(MAX_OUT), .CYC_W(CYC_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .base(base), .n_bursts(n_bursts),
    .aw_valid(m_awvalid), .aw_ready(m_awready), .aw_addr(m_awaddr),
    .w_valid(m_wvalid), .w_ready(m_wready), .w_data(m_wdata), .w_last(m_wlast),
    .b_valid(m_bvalid), .b_ready(m_bready),
    .busy(wr_busy), .done(wr_done), .cycles(wr_cycles), .inflight(wr_inflight)
  );

  btc_rd_engine #(.CNT_W(CNT_W), .MAX_OUT(MAX_OUT), .CYC_W(CYC_W), .OK_W(OK_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .base(base), .n_bursts(n_bursts),
    .ar_valid(m_arvalid), .ar_ready(m_arready), .ar_addr(m_araddr),
    .r_valid(m_rvalid), .r_data(m_rdata), .r_last(m_rlast), .r_ready(m_rready),
    .busy(rd_busy), .done(rd_done), .cycles(rd_cycles), .ok_count(ok_count),
    .inflight(rd_inflight)
  );

  assign m_awlen   = 8'(BURST_BEATS - 1);
  assign m_arlen   = 8'(BURST_BEATS - 1);
  assign m_awsize  = 3'(SIZE_CD);
  assign m_arsize  = 3'(SIZE_CD);
  assign m_awburst = 2'b01;
  assign m_arburst = 2'b01;
  assign m_wstrb   = '1;
  assign m_awcache = sb_cache;
  assign m_arcache = sb_cache;
  assign m_awprot  = sb_prot;
  assign m_arprot  = sb_prot;
  assign m_awuser  = sb_user;
  assign m_aruser  = sb_user;
endmodule

// File: rtl/btc_checker.sv
module btc_checker
  import btc_pkg::*;
#(
  parameter int MAX_OUT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              m_rlast,
  input logic              wr_start,
  input logic              wr_busy,
  input logic              rd_busy
);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  logic              aw_hs, w_hs, b_hs, ar_hs, rl_hs;
  logic [7:0]        wr_open, rd_open;
  logic [BEAT_W-1:0] wbeat;
  logic              aw_seen;
  logic [ADDR_W-1:0] aw_prev;

  assign aw_hs = m_awvalid && m_awready;
  assign w_hs  = m_wvalid && m_wready;
  assign b_hs  = m_bvalid && m_bready;
  assign ar_hs = m_arvalid && m_arready;
  assign rl_hs = m_rvalid && m_rready && m_rlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_open <= '0;
      rd_open <= '0;
      wbeat   <= '0;
      aw_seen <= 1'b0;
      aw_prev <= '0;
    end else begin
      wr_open <= wr_open + 8'(aw_hs) - 8'(b_hs);
      rd_open <= rd_open + 8'(ar_hs) - 8'(rl_hs);
      if (w_hs) wbeat <= m_wlast ? '0 : wbeat + BEAT_W'(1);
      if (wr_start) aw_seen <= 1'b0;
      else if (aw_hs) begin
        aw_seen <= 1'b1;
        aw_prev <= m_awaddr;
      end
    end
  end

  p_wr_open_r4: assert property (@(posedge clk) disable iff (!rst_n) wr_open <= 8'(MAX_OUT));
  p_rd_open_r4: assert property (@(posedge clk) disable iff (!rst_n) rd_open <= 8'(MAX_OUT));
  p_aw_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && aw_seen && !wr_start) |-> (m_awaddr == aw_prev + ADDR_W'(BURST_BYTES)));
  p_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
  p_wlast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    w_hs |-> (m_wlast == (wbeat == BEAT_W'(BURST_BEATS - 1))));
  p_no_rd_in_wr_r8: assert property (@(posedge clk) disable iff (!rst_n) wr_busy |=> !$rose(rd_busy));
  p_no_wr_in_rd_r8: assert property (@(posedge clk) disable iff (!rst_n) rd_busy |=> !$rose(wr_busy));
endmodule

bind burst_traffic_checker btc_checker #(.MAX_OUT(MAX_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
  .m_bvalid(m_bvalid), .m_bready(m_bready),
  .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rlast(m_rlast),
  .wr_start(wr_start), .wr_busy(wr_busy), .rd_busy(rd_busy)
);

// File: tb/burst_traffic_checker_tb_top.sv
`timescale 1ns/1ps
module burst_traffic_checker_tb_top;
  localparam int BLAT = 12;
  localparam int RLAT = 8;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [4:0] s_awaddr = 0, s_araddr = 0;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
  logic [31:0] s_wdata = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] m_awaddr, m_araddr;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize, m_awprot, m_arprot;
  logic [1:0] m_awburst, m_arburst;
  logic [3:0] m_awcache, m_arcache;
  logic [0:0] m_awuser, m_aruser;
  logic m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
  logic [127:0] m_wdata;
  logic [15:0] m_wstrb;
  logic m_bvalid = 0, m_rvalid = 0, m_rlast = 0;
  logic [127:0] m_rdata = 0;

  burst_traffic_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awcache(m_awcache), .m_awprot(m_awprot), .m_awuser(m_awuser),
    .m_awvalid(m_awvalid), .m_awready(1'b1),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(1'b1),
    .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arcache(m_arcache), .m_arprot(m_arprot), .m_aruser(m_aruser),
    .m_arvalid(m_arvalid), .m_arready(1'b1),
    .m_rdata(m_rdata), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and bus monitor
  logic [127:0] mem [0:255];
  logic [31:0] awq[$], arq[$];
  longint bq[$], ardue[$];
  longint cyc = 0;
  int wbeat = 0, rbeat = 0;
  logic [31:0] ph_base = 0;
  logic [7:0] exp_sb = 0;
  int aw_seen = 0, ar_seen = 0, aw_total = 0, ar_total = 0;
  int addr_err = 0, shape_err = 0, sb_err = 0;
  int wr_open = 0, rd_open = 0, wr_max = 0, rd_max = 0;
  longint aw_first = 0, ar_first = 0, b_last = 0, r_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bvalid <= 0; m_rvalid <= 0; m_rlast <= 0;
    end else begin
      cyc++;
      if (m_awvalid) begin
        if (aw_seen == 0) aw_first = cyc;
        if (m_awaddr !== ph_base + 32'(64 * aw_seen)) addr_err++;
        if (m_awlen !== 8'd3 || m_awsize !== 3'd4 || m_awburst !== 2'd1 || m_wstrb !== 16'hFFFF) shape_err++;
        if ({m_awcache, m_awprot, m_awuser} !== exp_sb) sb_err++;
        aw_seen++; aw_total++; wr_open++;
        awq.push_back(m_awaddr);
      end
      if (m_wvalid) begin
        mem[8'(awq[0][11:4] + 8'(wbeat))] = m_wdata;
        if (m_wlast !== (wbeat == 3)) shape_err++;
        if (wbeat == 3) begin
          wbeat = 0; void'(awq.pop_front()); bq.push_back(cyc + BLAT);
        end else wbeat++;
      end
      if (m_bvalid && m_bready) begin
        void'(bq.pop_front()); wr_open--; b_last = cyc;
      end
      if (wr_open > wr_max) wr_max = wr_open;
      m_bvalid <= (bq.size() > 0) && (bq[0] <= cyc);

      if (m_arvalid) begin
        if (ar_seen == 0) ar_first = cyc;
        if (m_araddr !== ph_base + 32'(64 * ar_seen)) addr_err++;
        if (m_arlen !== 8'd3 || m_arsize !== 3'd4 || m_arburst !== 2'd1) shape_err++;
        if ({m_arcache, m_arprot, m_aruser} !== exp_sb) sb_err++;
        ar_seen++; ar_total++; rd_open++;
        arq.push_back(m_araddr); ardue.push_back(cyc + RLAT);
      end
      if (m_rvalid && m_rready) begin
        if (rbeat == 3) begin
          rbeat = 0; void'(arq.pop_front()); void'(ardue.pop_front());
          rd_open--; r_last = cyc;
        end else rbeat++;
      end
      if (rd_open > rd_max) rd_max = rd_open;
      if (arq.size() > 0 && ardue[0] <= cyc) begin
        m_rvalid <= 1; m_rlast <= (rbeat == 3);
        m_rdata <= mem[8'(arq[0][11:4] + 8'(rbeat))];
      end else begin
        m_rvalid <= 0; m_rlast <= 0;
      end
    end
  end

  task automatic lite_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    while (!s_bvalid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lite_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    @(negedge clk);
  endtask

  task automatic wait_bit(input int b);
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      lite_rd(5'h00, st);
      if (st[b]) return;
    end
    chk("R7 done bit timeout", 0, 1);
  endtask

  function automatic logic [127:0] pat(input int k);
    return {4{32'(k)}};
  endfunction

  task automatic new_phase(input logic [31:0] b);
    ph_base = b; aw_seen = 0; ar_seen = 0; wr_max = 0; rd_max = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 awvalid after reset", m_awvalid, 0);
    chk("R11 arvalid after reset", m_arvalid, 0);
    lite_rd(5'h00, v); chk("R11 status reset", v, 0);
    lite_rd(5'h04, v); chk("R11 base reset", v, 0);
    lite_rd(5'h08, v); chk("R11 count reset", v, 0);
    lite_rd(5'h0C, v); chk("R11 sideband reset", v, 0);
    lite_rd(5'h18, v); chk("R11 match count reset", v, 0);
  endtask

  task automatic t_write_long();
    logic [31:0] v;
    int bad = 0;
    lite_wr(5'h04, 32'h2000);
    lite_wr(5'h08, 32);
    lite_wr(5'h0C, 32'h12F);
    exp_sb = {4'hF, 3'd2, 1'b1};
    new_phase(32'h2000);
    lite_wr(5'h00, 1);
    // R8: starts issued mid-phase must be ignored
    lite_wr(5'h00, 2);
    lite_wr(5'h00, 1);
    wait_bit(2);
    lite_rd(5'h00, v); chk("R7 write done, not busy", v[2:0], 3'b100);
    chk("R8 no read during write", ar_total, 0);
    chk("R8 restart ignored, bursts", aw_total, 32);
    chk("R2 write addresses", addr_err, 0);
    chk("R1 burst shape", shape_err, 0);
    chk("R9 sideband on write", sb_err, 0);
    chk("R4 write in flight peak", wr_max, 4);
    lite_rd(5'h10, v); chk("R5 write cycles", v, 64'(b_last - aw_first + 1));
    for (int k = 0; k < 128; k++) if (mem[k] !== pat(k)) bad++;
    chk("R3 write pattern", bad, 0);
  endtask

  task automatic t_read_long(input int exp_ok);
    logic [31:0] v;
    new_phase(32'h2000);
    lite_wr(5'h00, 2);
    wait_bit(3);
    lite_rd(5'h00, v); chk("R7 read done", v[3:0], 4'b1100);
    lite_rd(5'h18, v); chk("R6 match count", v, exp_ok);
    lite_rd(5'h14, v); chk("R5 read cycles", v, 64'(r_last - ar_first + 1));
    chk("R4 read in flight peak", rd_max, 4);
    chk("R2 read addresses", addr_err, 0);
    chk("R9 sideband on read", sb_err, 0);
  endtask

  task automatic t_short_both_bits();
    logic [31:0] v;
    int bad = 0, ar0;
    lite_wr(5'h04, 32'h400);
    lite_wr(5'h08, 3);
    new_phase(32'h400);
    ar0 = ar_total;
    lite_wr(5'h00, 3);
    wait_bit(2);
    chk("R8 both bits start write only", ar_total, ar0);
    chk("R4 write peak short", wr_max, 3);
    for (int k = 0; k < 12; k++) if (mem[64 + k] !== pat(k)) bad++;
    chk("R3 short pattern", bad, 0);
    new_phase(32'h400);
    lite_wr(5'h00, 2);
    wait_bit(3);
    lite_rd(5'h18, v); chk("R6 short match count", v, 12);
    chk("R4 read peak short", rd_max, 3);
    chk("R2 short addresses", addr_err, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int aw0 = aw_total;
    lite_wr(5'h08, 0);
    lite_wr(5'h00, 1);
    lite_rd(5'h00, v); chk("R10 zero count done", v[2:0], 3'b100);
    lite_rd(5'h10, v); chk("R10 zero count cycles", v, 0);
    chk("R10 zero count no address", aw_total, aw0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_long();
    t_read_long(128);
    mem[5] = mem[5] ^ 128'h1;
    mem[77][100] = ~mem[77][100];
    t_read_long(126);
    t_short_both_bits();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule